// File: doc/BRIEF.md
# Pixel Output Formatter with Data-Valid

This block sits at the end of an imaging pixel pipeline. It receives one processed pixel per sample strobe: a 10-bit value, an out-of-range flag, a 2-bit channel number and the data-valid bit carried in the pixel's coefficient words. It drives the output pad group, which consists of the data bus, an active-low data-valid strobe, the out-of-range flag, a 3-bit channel code and a first-word phase marker.

The bus can carry each pixel in one of two forms. In the first form, the pixel appears as one 10-bit word for one cycle. In the second form, it appears as two 8-bit words on the upper eight bus lines in consecutive cycles, so the words run at twice the pixel rate. The data-valid strobe is taken from one of two sources. The first source is a per-channel enable mask, which can be used to pick out single colours. The second source is the bit embedded in the coefficients. In hold mode, the bus keeps the last valid pixel and ignores pixels that are not valid. A single active-low enable pin releases the whole pad group.

Top module: `pix_out_fmt`

## Requirements
- R1: While reset is asserted, and until the first pixel arrives, the outputs hold fixed values. bus_o, oor_o, cc_o and phase_o are 0. dv_no is 1. pad_en_o is 1 when oe_ni is 0.
- R2: In 10-bit mode (mux8_i=0), the clock edge that captures pix_vld_i=1 starts one presentation cycle. In that cycle, bus_o carries the pixel, oor_o carries its flag, and cc_o is {channel,0}.
- R3: In 8-bit mode (mux8_i=1), the pixel takes two cycles. The first cycle shows {d9..d2,00} with phase_o=1 and cc_o LSB 0. The second cycle shows {d1,d0,00000,oor,00} with phase_o=0 and cc_o LSB 1. After that, the bus keeps showing the second word.
- R4: dv_no is 0 in every presentation cycle of a pixel whose data-valid is active. That is one cycle in 10-bit mode and two cycles in 8-bit mode. dv_no is 1 at all other times.
- R5: With dv_src_reg_i=1, a pixel's data-valid is dv_mask_i[channel]. The channel numbers are red=0, green=1 and blue=2, so cc_o is 00x, 01x and 10x respectively. Channel 3 is never valid.
- R6: With dv_src_reg_i=0, a pixel's data-valid is coef_dv_i.
- R7: With hold_i=1, bus_o and oor_o change only on pixels whose data-valid is active. cc_o still follows every pixel. The held value stays for any number of cycles.
- R8: With hold_i=0, bus_o and oor_o update on every pixel, whatever its data-valid.
- R9: While oe_ni=1, the pad group is released. pad_en_o, bus_o, oor_o, cc_o and phase_o are 0, and dv_no is 1. Internal capture continues while the pads are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oe_ni | input | 1 | Pad enable, active low; 1 releases all outputs |
| mux8_i | input | 1 | 1 selects two 8-bit words per pixel |
| hold_i | input | 1 | 1 holds the bus between valid pixels |
| dv_src_reg_i | input | 1 | 1 takes data-valid from the channel mask, 0 from the coefficients |
| dv_mask_i | input | 3 | Per-channel data-valid enable, bit n for channel n |
| pix_vld_i | input | 1 | Pixel sample strobe |
| pix_data_i | input | 10 | Pixel value |
| pix_oor_i | input | 1 | Pixel out-of-range flag |
| pix_chan_i | input | 2 | Pixel channel number |
| coef_dv_i | input | 1 | Data-valid bit embedded in the coefficients |
| bus_o | output | 10 | Output data bus |
| oor_o | output | 1 | Out-of-range flag of the presented pixel |
| cc_o | output | 3 | Channel code {channel, word index} |
| dv_no | output | 1 | Data-valid strobe, active low |
| phase_o | output | 1 | High on the first word of an 8-bit pair |
| pad_en_o | output | 1 | Pad drivers enabled |

## Verification
The bench checks the second 8-bit word, bit by bit.
- A design that swaps d1 and d0 produces the wrong word.
- A design that drops the out-of-range flag into the wrong lane produces the wrong word.
- A design that drops the second-word index from cc_o mismatches on cc_o.

Hold mode is run with a red-only mask across mixed colours and long idle gaps.
- A design that updates on invalid pixels is caught because the bus leaves the red value.
- A design that freezes the channel code along with the data is caught because cc_o stops following the pixels.

The strobe is checked in both bus widths. A design that pulses only once in 8-bit mode leaves dv_no high on the second word. So does one that ignores the embedded coefficient bit or indexes the mask by the wrong channel.

Finally, the pads are disabled in the middle of a stream and then enabled again. This shows that released outputs sit at idle levels and that capture carried on underneath.

// File: rtl/pof_pkg.sv
package pof_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_FIRST  = 2'd1,
    SLOT_SECOND = 2'd2,
    SLOT_SINGLE = 2'd3
  } slot_e;
endpackage

// File: rtl/pof_dv_sel.sv
module pof_dv_sel #(
  parameter int NCH = 3,
  parameter int CW  = 2
) (
  input  logic           sel_reg_i,
  input  logic [NCH-1:0] mask_i,
  input  logic [CW-1:0]  chan_i,
  input  logic           coef_dv_i,
  output logic           dv_o
);
  logic [NCH-1:0] hit;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    assign hit[gi] = mask_i[gi] && (chan_i == CW'(gi));
  end

  assign dv_o = sel_reg_i ? (|hit) : coef_dv_i;
endmodule

// File: rtl/pof_capture.sv
module pof_capture
  import pof_pkg::*;
#(
  parameter int DW = 10,
  parameter int CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic          mux8_i,
  input  logic          hold_i,
  input  logic          dv_i,
  input  logic [DW-1:0] data_i,
  input  logic          oor_i,
  input  logic [CW-1:0] chan_i,
  output logic [DW-1:0] data_o,
  output logic          oor_o,
  output logic [CW-1:0] chan_o,
  output logic          dvf_o,
  output slot_e         slot_o
);
  logic [DW-1:0] data_q;
  logic          oor_q;
  logic [CW-1:0] chan_q;
  logic          dvf_q;
  slot_e         slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oor_q  <= 1'b0;
      chan_q <= '0;
      dvf_q  <= 1'b0;
      slot_q <= SLOT_IDLE;
    end else if (vld_i) begin
      chan_q <= chan_i;
      dvf_q  <= dv_i;
      slot_q <= mux8_i ? SLOT_FIRST : SLOT_SINGLE;
      // latch mode: only valid pixels reach the bus
      if (!hold_i || dv_i) begin
        data_q <= data_i;
        oor_q  <= oor_i;
      end
    end else if (slot_q == SLOT_FIRST) begin
      slot_q <= SLOT_SECOND;
    end else begin
      slot_q <= SLOT_IDLE;
    end
  end

  assign data_o = data_q;
  assign oor_o  = oor_q;
  assign chan_o = chan_q;
  assign dvf_o  = dvf_q;
  assign slot_o = slot_q;

  // R7
  property p_hold;
    @(posedge clk_i) disable iff (!rst_ni)
      (hold_i && vld_i && !dv_i) |=> $stable(data_q);
  endproperty
  hold_keep_chk: assert property (p_hold);

  // R8
  property p_upd;
    @(posedge clk_i) disable iff (!rst_ni)
      (!hold_i && vld_i) |=> (data_q == $past(data_i));
  endproperty
  upd_every_chk: assert property (p_upd);

  // R3
  property p_pair;
    @(posedge clk_i) disable iff (!rst_ni)
      (slot_q == SLOT_FIRST && !vld_i) |=> (slot_q == SLOT_SECOND);
  endproperty
  pair_order_chk: assert property (p_pair);
endmodule

// File: rtl/pof_word_mux.sv
module pof_word_mux
  import pof_pkg::*;
#(
  parameter int DW = 10,
  parameter int CW = 2
) (
  input  logic          mux8_i,
  input  slot_e         slot_i,
  input  logic [DW-1:0] data_i,
  input  logic          oor_i,
  input  logic [CW-1:0] chan_i,
  input  logic          dvf_i,
  output logic [DW-1:0] word_o,
  output logic [CW:0]   cc_o,
  output logic          dvn_o,
  output logic          phase_o
);
  localparam int HW = DW - 2;      // narrow word width, carried on the top lanes
  localparam int PADW = HW - 3;    // don't-care lanes of the second word

  logic [HW-1:0] first_w, second_w;

  assign first_w  = data_i[DW-1:2];
  assign second_w = {data_i[1:0], {PADW{1'b0}}, oor_i};

  always_comb begin
    word_o  = data_i;
    cc_o    = {chan_i, 1'b0};
    phase_o = 1'b0;
    dvn_o   = 1'b1;
    if (!mux8_i) begin
      dvn_o = !(slot_i == SLOT_SINGLE && dvf_i);
    end else if (slot_i == SLOT_FIRST) begin
      word_o  = {first_w, 2'b00};
      phase_o = 1'b1;
      dvn_o   = !dvf_i;
    end else begin
      word_o = {second_w, 2'b00};
      cc_o   = {chan_i, slot_i == SLOT_SECOND};
      dvn_o  = !(slot_i == SLOT_SECOND && dvf_i);
    end
  end
endmodule

// File: rtl/pof_pad_gate.sv
module pof_pad_gate #(
  parameter int N = 8
) (
  input  logic         en_i,
  input  logic [N-1:0] val_i,
  input  logic [N-1:0] idle_i,
  output logic [N-1:0] pad_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_pad
    assign pad_o[gi] = en_i ? val_i[gi] : idle_i[gi];
  end
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
  import pof_pkg::*;
#(
  parameter int DW  = 10,
  parameter int NCH = 3,
  parameter int CW  = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           oe_ni,
  input  logic           mux8_i,
  input  logic           hold_i,
  input  logic           dv_src_reg_i,
  input  logic [NCH-1:0] dv_mask_i,
  input  logic           pix_vld_i,
  input  logic [DW-1:0]  pix_data_i,
  input  logic           pix_oor_i,
  input  logic [CW-1:0]  pix_chan_i,
  input  logic           coef_dv_i,
  output logic [DW-1:0]  bus_o,
  output logic           oor_o,
  output logic [CW:0]    cc_o,
  output logic           dv_no,
  output logic           phase_o,
  output logic           pad_en_o
);
  localparam int PW = DW + CW + 4;   // bus, oor, cc, dv, phase

  logic          dv_act;
  logic [DW-1:0] cap_data;
  logic          cap_oor;
  logic [CW-1:0] cap_chan;
  logic          cap_dvf;
  slot_e         cap_slot;
  logic [DW-1:0] word;
  logic [CW:0]   cc_w;
  logic          dvn_w;
  logic          phase_w;
  logic [PW-1:0] pad_val, pad_idle, pad_out;

  pof_dv_sel #(.NCH(NCH), .CW(CW)) u_dv (
    .sel_reg_i (dv_src_reg_i),
    .mask_i    (dv_mask_i),
    .chan_i    (pix_chan_i),
    .coef_dv_i (coef_dv_i),
    .dv_o      (dv_act)
  );

  pof_capture #(.DW(DW), .CW(CW)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (pix_vld_i),
    .mux8_i (mux8_i),
    .hold_i (hold_i),
    .dv_i   (dv_act),
    .data_i (pix_data_i),
    .oor_i  (pix_oor_i),
    .chan_i (pix_chan_i),
    .data_o (cap_data),
    .oor_o  (cap_oor),
    .chan_o (cap_chan),
    .dvf_o  (cap_dvf),
    .slot_o (cap_slot)
  );

  pof_word_mux #(.DW(DW), .CW(CW)) u_mux (
    .mux8_i  (mux8_i),
    .slot_i  (cap_slot),
    .data_i  (cap_data),
    .oor_i   (cap_oor),
    .chan_i  (cap_chan),
    .dvf_i   (cap_dvf),
    .word_o  (word),
    .cc_o    (cc_w),
    .dvn_o   (dvn_w),
    .phase_o (phase_w)
  );

  assign pad_val  = {word, cap_oor, cc_w, dvn_w, phase_w};
  assign pad_idle = {{(DW + CW + 2){1'b0}}, 1'b1, 1'b0};   // strobe idles high

  pof_pad_gate #(.N(PW)) u_pad (
    .en_i   (!oe_ni),
    .val_i  (pad_val),
    .idle_i (pad_idle),
    .pad_o  (pad_out)
  );

  assign {bus_o, oor_o, cc_o, dv_no, phase_o} = pad_out;
  assign pad_en_o = !oe_ni;

  // R9
  property p_release;
    @(posedge clk_i) disable iff (!rst_ni)
      oe_ni |-> (!pad_en_o && dv_no && bus_o == '0 && !oor_o && cc_o == '0);
  endproperty
  release_idle_chk: assert property (p_release);

  // R5
  property p_invalid_quiet;
    @(posedge clk_i) disable iff (!rst_ni)
      ($past(pix_vld_i && !dv_act) && !oe_ni) |-> dv_no;
  endproperty
  invalid_quiet_chk: assert property (p_invalid_quiet);

  // R4
  property p_valid_strobe;
    @(posedge clk_i) disable iff (!rst_ni)
      ($past(pix_vld_i && dv_act) && !oe_ni) |-> !dv_no;
  endproperty
  valid_strobe_chk: assert property (p_valid_strobe);

  // R3
  property p_phase_once;
    @(posedge clk_i) disable iff (!rst_ni)
      (phase_o && !pix_vld_i) |=> !phase_o;
  endproperty
  phase_once_chk: assert property (p_phase_once);
endmodule

// File: tb/sim_pix_out_fmt.sv
`timescale 1ns/1ps
module sim_pix_out_fmt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oe_n = 1'b0, mux8 = 1'b0, hold = 1'b0, src_reg = 1'b1;
  logic [2:0] mask = 3'b111;
  logic       vld = 1'b0, oor = 1'b0, cdv = 1'b0;
  logic [9:0] data = '0;
  logic [1:0] chan = '0;
  logic [9:0] bus;
  logic       oor_q, dvn, ph, pen;
  logic [2:0] cc;

  // next-cycle configuration, applied inside step()
  logic       nx_oe_n = 1'b0, nx_mux8 = 1'b0, nx_hold = 1'b0, nx_src = 1'b1;
  logic [2:0] nx_mask = 3'b111;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pix_out_fmt u0 (
    .clk_i(clk), .rst_ni(rst_n), .oe_ni(oe_n), .mux8_i(mux8), .hold_i(hold),
    .dv_src_reg_i(src_reg), .dv_mask_i(mask), .pix_vld_i(vld), .pix_data_i(data),
    .pix_oor_i(oor), .pix_chan_i(chan), .coef_dv_i(cdv), .bus_o(bus), .oor_o(oor_q),
    .cc_o(cc), .dv_no(dvn), .phase_o(ph), .pad_en_o(pen)
  );

  // expected item: {bus, oor, cc, dvn, phase, pad_en}
  logic [16:0] exp_q[$];
  string       tag_q[$];

  // reference state
  logic [9:0] m_data = '0;
  logic       m_oor = 1'b0, m_dv = 1'b0;
  logic [1:0] m_chan = '0;
  int         m_slot = 0;   // 0 idle, 1 first, 2 second, 3 single

  function automatic logic [16:0] expect_now();
    logic [9:0] b; logic [2:0] c; logic dn, p;
    if (oe_n) return {10'b0, 1'b0, 3'b0, 1'b1, 1'b0, 1'b0};
    c = {m_chan, 1'b0}; p = 1'b0;
    if (!mux8) begin
      b = m_data; dn = !(m_slot == 3 && m_dv);
    end else if (m_slot == 1) begin
      b = {m_data[9:2], 2'b00}; p = 1'b1; dn = !m_dv;
    end else begin
      b = {m_data[1:0], 5'b00000, m_oor, 2'b00};
      c = {m_chan, m_slot == 2};
      dn = !(m_slot == 2 && m_dv);
    end
    return {b, m_oor, c, dn, p, 1'b1};
  endfunction

  task automatic step(input logic v, input logic [9:0] d, input logic o,
                      input logic [1:0] ch, input logic cd, input string tag);
    logic dvx;
    @(negedge clk); #1;
    oe_n = nx_oe_n; mux8 = nx_mux8; hold = nx_hold; src_reg = nx_src; mask = nx_mask;
    vld = v; data = d; oor = o; chan = ch; cdv = cd;
    if (v) begin
      dvx = src_reg ? ((ch < 2'd3) ? mask[ch] : 1'b0) : cd;
      m_chan = ch; m_dv = dvx; m_slot = mux8 ? 1 : 3;
      if (!hold || dvx) begin m_data = d; m_oor = o; end
    end else if (m_slot == 1) m_slot = 2;
    else m_slot = 0;
    exp_q.push_back(expect_now());
    tag_q.push_back(tag);
  endtask

  task automatic pix(input logic [9:0] d, input logic o, input logic [1:0] ch,
                     input logic cd, input int gap, input string tag);
    step(1'b1, d, o, ch, cd, tag);
    for (int i = 0; i < gap; i++) step(1'b0, 10'h0, 1'b0, 2'd0, 1'b0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [16:0] e, a;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        a = {bus, oor_q, cc, dvn, ph, pen};
        n_chk++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: bus/oor/cc/dvn/ph/pen actual %h %b %b %b %b %b expected %h %b %b %b %b %b",
                   t, a[16:7], a[6], a[5:3], a[2], a[1], a[0],
                   e[16:7], e[6], e[5:3], e[2], e[1], e[0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    n_chk++;
    if ({bus, oor_q, cc, dvn, ph, pen} !== {10'b0, 1'b0, 3'b0, 1'b1, 1'b0, 1'b1}) begin
      n_bad++;
      $display("FAIL R1: actual %h %b %b %b %b %b expected 000 0 000 1 0 1",
               bus, oor_q, cc, dvn, ph, pen);
    end
    rst_n = 1'b1;
    step(1'b0, 10'h0, 1'b0, 2'd0, 1'b0, "R1");

    // R2 10-bit mode, all channels valid
    pix(10'h2a5, 1'b0, 2'd0, 1'b0, 0, "R2");
    pix(10'h15a, 1'b1, 2'd1, 1'b0, 2, "R2");
    pix(10'h3ff, 1'b0, 2'd2, 1'b0, 1, "R2");
    pix(10'h001, 1'b1, 2'd0, 1'b0, 3, "R4");

    // R5 mask picks green only
    nx_mask = 3'b010;
    pix(10'h111, 1'b0, 2'd0, 1'b0, 1, "R5");
    pix(10'h222, 1'b0, 2'd1, 1'b0, 1, "R5");
    pix(10'h333, 1'b1, 2'd2, 1'b0, 1, "R5");
    pix(10'h044, 1'b0, 2'd3, 1'b0, 1, "R5");

    // R6 embedded bit
    nx_src = 1'b0;
    pix(10'h0f0, 1'b0, 2'd0, 1'b1, 1, "R6");
    pix(10'h00f, 1'b0, 2'd1, 1'b0, 1, "R6");
    pix(10'h3c3, 1'b1, 2'd2, 1'b1, 0, "R6");

    // R8 no hold: invalid pixels still update
    pix(10'h155, 1'b1, 2'd1, 1'b0, 1, "R8");
    pix(10'h0aa, 1'b0, 2'd2, 1'b0, 1, "R8");

    // R7 hold with red-only mask
    nx_src = 1'b1; nx_mask = 3'b001; nx_hold = 1'b1;
    pix(10'h123, 1'b1, 2'd0, 1'b0, 1, "R7");
    pix(10'h3a0, 1'b0, 2'd1, 1'b0, 1, "R7");
    pix(10'h05c, 1'b0, 2'd2, 1'b0, 20, "R7");
    pix(10'h2e1, 1'b0, 2'd0, 1'b0, 2, "R7");
    pix(10'h0d2, 1'b1, 2'd2, 1'b0, 1, "R7");

    // R3 8-bit mode, back-to-back pairs and gaps
    nx_hold = 1'b0; nx_mask = 3'b111; nx_mux8 = 1'b1;
    step(1'b0, 10'h0, 1'b0, 2'd0, 1'b0, "R3");
    pix(10'h2b6, 1'b1, 2'd0, 1'b0, 1, "R3");
    pix(10'h1c9, 1'b0, 2'd1, 1'b0, 1, "R3");
    pix(10'h3fe, 1'b1, 2'd2, 1'b0, 4, "R3");
    pix(10'h001, 1'b0, 2'd2, 1'b0, 1, "R3");

    // R4 8-bit strobe with mask and embedded source
    nx_mask = 3'b100;
    pix(10'h3a5, 1'b0, 2'd0, 1'b0, 1, "R4");
    pix(10'h25a, 1'b1, 2'd2, 1'b0, 1, "R4");
    nx_src = 1'b0;
    pix(10'h0c3, 1'b0, 2'd1, 1'b1, 2, "R4");

    // R7 hold in 8-bit mode
    nx_src = 1'b1; nx_mask = 3'b010; nx_hold = 1'b1;
    pix(10'h199, 1'b1, 2'd1, 1'b0, 1, "R7");
    pix(10'h266, 1'b0, 2'd0, 1'b0, 3, "R7");

    // R9 release pads mid-stream, then restore
    nx_hold = 1'b0; nx_mask = 3'b111; nx_mux8 = 1'b0; nx_oe_n = 1'b1;
    pix(10'h2f0, 1'b1, 2'd1, 1'b0, 1, "R9");
    pix(10'h10f, 1'b1, 2'd2, 1'b0, 0, "R9");
    nx_oe_n = 1'b0;
    step(1'b0, 10'h0, 1'b0, 2'd0, 1'b0, "R9");
    pix(10'h0a5, 1'b0, 2'd0, 1'b0, 2, "R9");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule